// File: doc/BRIEF.md
# Prefix-Extended Four-Operand Instruction Decoder

This decode stage takes a stream of 32-bit words. A word is either a plain instruction or a prefix word. A prefix word must be followed by an instruction word. The prefix widens the register numbers by one bit, carries a 12-bit opcode extension and supplies an extra byte. Each decoded instruction comes out in a four-operand form: source A, source B, a third operand and a destination. The third operand is either an 8-bit immediate or a 6-bit register number. The rules that pick it depend on the instruction class. For the floating-point add, subtract and multiply operations, the extra byte from the prefix becomes a rounding mode for that one instruction.

A small state machine tracks the word stream. In `S_IDLE`, a valid plain word is decoded at once and the machine stays in `S_IDLE`. A valid prefix word is captured and the machine moves to `S_WAIT_INSN`. In `S_WAIT_INSN`, cycles with no valid word keep the machine waiting. The next valid word is decoded together with the held prefix and the machine returns to `S_IDLE`. If that next word is itself a prefix, the result is an illegal-instruction report. All outputs are registered, and `out_valid` pulses for one cycle, on the clock edge after the instruction word is accepted.

Word layouts, with bit 31 as the most significant bit:
- A prefix word has 0xFF in bits 31:24. Its remaining fields are:
  - bits 23:20: register extension. Bit 20 extends the destination, bit 21 extends source A, bit 22 extends source B, and bit 23 is reserved and must be 0.
  - bits 19:8: opcode extension.
  - bits 7:0: the extra byte.
- An instruction word has these fields:
  - bits 31:24: opcode. The value 0xFF is never an opcode.
  - bits 23:19: destination.
  - bits 18:14: source A.
  - bits 13:9: source B.
  - bits 8:0: reserved, must be 0.

Top module: `xop_decoder`

## Requirements
- R1: While `rst_n` is low, and after it rises, `out_valid` is 0 and the decoder is in `S_IDLE`. A reset asserted during `S_WAIT_INSN` discards the held prefix, so the next plain word decodes with `out_prefixed`=0.
- R2: A valid plain word decodes as follows.
  - `out_valid` is 1 exactly one cycle after the word is accepted, for one cycle only.
  - `out_prefixed`=0 and `out_opx`=0.
  - The 5-bit register fields are zero-extended to 6 bits.
  - A word presented with `in_valid`=0 produces nothing.
- R3: After a prefix word, `out_valid` stays 0 for any number of cycles until a valid instruction word arrives. That word is then decoded with the prefix applied.
- R4: With a prefix, prefix bit 20 becomes bit 5 of `out_dst`, bit 21 becomes bit 5 of `out_src_a`, and bit 22 becomes bit 5 of `out_src_b`.
- R5: The register class is opcode 0x20 with an opcode extension of 0. It gives `out_third_is_imm`=0. `out_third` is the extra byte's bits 5:0 when prefixed, and the destination number when not prefixed.
- R6: The immediate class is opcode 0x30 with an opcode extension of 0. It gives `out_third_is_imm`=1. `out_third` is the extra byte when prefixed, and 0 when not prefixed.
- R7: Any other opcode is the default class. It gives `out_third_is_imm`=0 and `out_third` equal to the destination number, and the extra byte is ignored.
- R8: The FP class is opcodes 0x10 (add), 0x11 (subtract) and 0x12 (multiply). When prefixed, they give `out_rnd_mode` equal to the extra byte and `out_rnd_valid`=1. Their third operand is the destination number.
- R9: An FP-class instruction without a prefix gives `out_rnd_mode`=0x00 (the nearest-even code) and `out_rnd_valid`=0.
- R10: Every non-FP instruction gives `out_rnd_mode`=0x00 and `out_rnd_valid`=0, even when a prefix supplied a nonzero extra byte.
- R11: With a prefix, `out_opx` equals prefix bits 19:8. A nonzero opcode extension makes the instruction default class, whatever its opcode.
- R12: A prefix followed by a second prefix word gives the following result, after which the decoder is in `S_IDLE`:
  - `out_valid`=1 and `out_illegal`=1.
  - Every other output is 0.
- R13: The same illegal result (R12) is produced for either of two malformed inputs:
  - an instruction whose reserved bits 8:0 are nonzero;
  - a prefix whose bit 23 is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | `in_word` holds a word this cycle |
| in_word | input | 32 | Prefix or instruction word |
| out_valid | output | 1 | One-cycle pulse: decoded result present |
| out_illegal | output | 1 | Result is an illegal-instruction report |
| out_prefixed | output | 1 | Instruction carried a prefix |
| out_opcode | output | 8 | Base opcode |
| out_opx | output | 12 | Opcode extension (0 when not prefixed) |
| out_src_a | output | 6 | Source A register |
| out_src_b | output | 6 | Source B register |
| out_dst | output | 6 | Destination register |
| out_third_is_imm | output | 1 | Third operand is an immediate |
| out_third | output | 8 | Third operand: immediate or zero-extended register |
| out_rnd_mode | output | 8 | Rounding mode |
| out_rnd_valid | output | 1 | Rounding mode came from the instruction |

## Verification
The assertions check four properties on every cycle:
- a prefix or a waiting cycle never produces an output pulse;
- a per-instruction rounding mode only ever appears on a prefixed result;
- an illegal report carries no operand fields;
- unprefixed results never use the widened register bit, and an absent rounding mode always reads as the nearest-even code.

Only the bench scenarios can show the actual operand values for each class, with and without a prefix:
- which extra-byte bits reach the third operand;
- which register-extension bit lands on which register;
- that a nonzero opcode extension falls back to the default class;
- that a reset in the middle of a prefix pair discards the prefix.

// File: rtl/xop_pkg.sv
package xop_pkg;
    parameter int WORD_W = 32;
    parameter int OPC_W  = 8;
    parameter int BREG_W = 5;
    parameter int WX_W   = 4;
    parameter int OPX_W  = 12;
    parameter int XTRA_W = 8;

    localparam int XREG_W     = BREG_W + 1;
    localparam int BODY_W     = WORD_W - OPC_W;
    localparam int RSV_W      = WORD_W - OPC_W - 3 * BREG_W;
    localparam int NREG       = 3;

    localparam logic [OPC_W-1:0]  PFX_MARK = 8'hFF;
    localparam logic [OPC_W-1:0]  OPC_FADD = 8'h10;
    localparam logic [OPC_W-1:0]  OPC_FSUB = 8'h11;
    localparam logic [OPC_W-1:0]  OPC_FMUL = 8'h12;
    localparam logic [OPC_W-1:0]  OPC_ADD  = 8'h20;
    localparam logic [OPC_W-1:0]  OPC_ADDI = 8'h30;
    localparam logic [XTRA_W-1:0] RNE_CODE = 8'h00;

    typedef enum logic [1:0] {CLS_DEFAULT, CLS_REG, CLS_IMM, CLS_FP} cls_e;
    typedef enum logic {S_IDLE, S_WAIT_INSN} st_e;

    typedef struct packed {
        logic [OPC_W-1:0]  opc;
        logic [OPX_W-1:0]  opx;
        logic              pfx;
        logic [XREG_W-1:0] ra;
        logic [XREG_W-1:0] rb;
        logic [XREG_W-1:0] rd;
        logic              third_imm;
        logic [XTRA_W-1:0] third;
        logic [XTRA_W-1:0] rnd;
        logic              rnd_ok;
    } dec_t;
endpackage

// File: rtl/xop_class_lut.sv
module xop_class_lut
    import xop_pkg::*;
(
    input  logic [OPC_W-1:0] opc,
    input  logic [OPX_W-1:0] opx,
    output cls_e             cls
);
    always_comb begin
        cls = CLS_DEFAULT;
        if (opx == '0) begin
            unique case (opc)
                OPC_FADD, OPC_FSUB, OPC_FMUL: cls = CLS_FP;
                OPC_ADD:                      cls = CLS_REG;
                OPC_ADDI:                     cls = CLS_IMM;
                default:                      cls = CLS_DEFAULT;
            endcase
        end
    end
endmodule

// File: rtl/xop_operand_former.sv
module xop_operand_former
    import xop_pkg::*;
(
    input  logic              pfx_ok,
    input  logic [BODY_W-1:0] pfx_body,
    input  logic [WORD_W-1:0] insn,
    output dec_t              dec,
    output logic              bad
);
    logic [WX_W-1:0]   wx;
    logic [OPX_W-1:0]  opx;
    logic [XTRA_W-1:0] xb;
    logic [NREG-1:0][BREG_W-1:0] base_r;
    logic [NREG-1:0][XREG_W-1:0] wide_r;
    cls_e cls;

    assign wx  = pfx_ok ? pfx_body[BODY_W-1 -: WX_W] : '0;
    assign opx = pfx_ok ? pfx_body[XTRA_W +: OPX_W] : '0;
    assign xb  = pfx_ok ? pfx_body[XTRA_W-1:0] : '0;

    // index 0 = destination, 1 = source A, 2 = source B
    assign base_r[0] = insn[WORD_W-OPC_W-1 -: BREG_W];
    assign base_r[1] = insn[WORD_W-OPC_W-BREG_W-1 -: BREG_W];
    assign base_r[2] = insn[WORD_W-OPC_W-2*BREG_W-1 -: BREG_W];

    for (genvar g = 0; g < NREG; g++) begin : g_widen
        assign wide_r[g] = {wx[g], base_r[g]};
    end

    assign bad = wx[WX_W-1] | (insn[RSV_W-1:0] != '0);

    xop_class_lut cls_i (
        .opc (insn[WORD_W-1 -: OPC_W]),
        .opx (opx),
        .cls (cls)
    );

    always_comb begin
        dec           = '0;
        dec.opc       = insn[WORD_W-1 -: OPC_W];
        dec.opx       = opx;
        dec.pfx       = pfx_ok;
        dec.rd        = wide_r[0];
        dec.ra        = wide_r[1];
        dec.rb        = wide_r[2];
        dec.third_imm = 1'b0;
        dec.third     = {{(XTRA_W-XREG_W){1'b0}}, wide_r[0]};
        dec.rnd       = RNE_CODE;
        dec.rnd_ok    = 1'b0;
        unique case (cls)
            CLS_REG: begin
                if (pfx_ok) dec.third = {{(XTRA_W-XREG_W){1'b0}}, xb[XREG_W-1:0]};
            end
            CLS_IMM: begin
                dec.third_imm = 1'b1;
                dec.third     = xb;
            end
            CLS_FP: begin
                if (pfx_ok) begin
                    dec.rnd    = xb;
                    dec.rnd_ok = 1'b1;
                end
            end
            CLS_DEFAULT: begin
            end
        endcase
    end
endmodule

// File: rtl/xop_seq_fsm.sv
module xop_seq_fsm
    import xop_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic in_valid,
    input  logic is_pfx,
    output st_e  state_q,
    output logic capture,
    output logic emit,
    output logic pair
);
    st_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        capture = 1'b0;
        emit    = 1'b0;
        pair    = 1'b0;
        unique case (state_q)
            S_IDLE: begin
                if (in_valid && is_pfx) begin
                    capture = 1'b1;
                    state_d = S_WAIT_INSN;
                end else if (in_valid) begin
                    emit = 1'b1;
                end
            end
            S_WAIT_INSN: begin
                if (in_valid) begin
                    emit    = 1'b1;
                    pair    = is_pfx;
                    state_d = S_IDLE;
                end
            end
        endcase
    end
endmodule

// File: rtl/xop_decoder.sv
module xop_decoder
    import xop_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] in_word,
    output logic              out_valid,
    output logic              out_illegal,
    output logic              out_prefixed,
    output logic [OPC_W-1:0]  out_opcode,
    output logic [OPX_W-1:0]  out_opx,
    output logic [XREG_W-1:0] out_src_a,
    output logic [XREG_W-1:0] out_src_b,
    output logic [XREG_W-1:0] out_dst,
    output logic              out_third_is_imm,
    output logic [XTRA_W-1:0] out_third,
    output logic [XTRA_W-1:0] out_rnd_mode,
    output logic              out_rnd_valid
);
    st_e  state_q;
    logic is_pfx, capture, emit, pair, bad;
    logic [BODY_W-1:0] pfx_q;
    dec_t dec, res_q;
    logic valid_q, ill_q;

    assign is_pfx = (in_word[WORD_W-1 -: OPC_W] == PFX_MARK);

    xop_seq_fsm fsm_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .is_pfx   (is_pfx),
        .state_q  (state_q),
        .capture  (capture),
        .emit     (emit),
        .pair     (pair)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       pfx_q <= '0;
        else if (capture) pfx_q <= in_word[BODY_W-1:0];
    end

    xop_operand_former form_i (
        .pfx_ok   (state_q == S_WAIT_INSN),
        .pfx_body (pfx_q),
        .insn     (in_word),
        .dec      (dec),
        .bad      (bad)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            ill_q   <= 1'b0;
            res_q   <= '0;
        end else begin
            valid_q <= emit;
            if (emit) begin
                if (pair || bad) begin
                    res_q <= '0;
                    ill_q <= 1'b1;
                end else begin
                    res_q <= dec;
                    ill_q <= 1'b0;
                end
            end
        end
    end

    assign out_valid        = valid_q;
    assign out_illegal      = ill_q;
    assign out_prefixed     = res_q.pfx;
    assign out_opcode       = res_q.opc;
    assign out_opx          = res_q.opx;
    assign out_src_a        = res_q.ra;
    assign out_src_b        = res_q.rb;
    assign out_dst          = res_q.rd;
    assign out_third_is_imm = res_q.third_imm;
    assign out_third        = res_q.third;
    assign out_rnd_mode     = res_q.rnd;
    assign out_rnd_valid    = res_q.rnd_ok;

    a_r3_wait_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_WAIT_INSN && !in_valid) |=> (!out_valid && state_q == S_WAIT_INSN));

    a_r3_prefix_no_emit: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_IDLE && in_valid && is_pfx) |=> !out_valid);

    a_r9_mode_needs_prefix: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_rnd_valid) |-> out_prefixed);

    a_r10_absent_mode_rne: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_rnd_valid) |-> (out_rnd_mode == RNE_CODE));

    a_r12_illegal_clean: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_illegal) |-> (!out_prefixed && !out_rnd_valid && out_dst == '0 && out_third == '0));

    a_r2_plain_narrow: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_prefixed) |-> (!out_dst[XREG_W-1] && !out_src_a[XREG_W-1] && !out_src_b[XREG_W-1] && out_opx == '0));
endmodule

// File: tb/xop_decoder_tb.sv
`timescale 1ns/1ps
module xop_decoder_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] in_word = '0;
    logic        out_valid, out_illegal, out_prefixed, out_third_is_imm, out_rnd_valid;
    logic [7:0]  out_opcode, out_third, out_rnd_mode;
    logic [11:0] out_opx;
    logic [5:0]  out_src_a, out_src_b, out_dst;

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    xop_decoder dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_word(in_word),
        .out_valid(out_valid), .out_illegal(out_illegal), .out_prefixed(out_prefixed),
        .out_opcode(out_opcode), .out_opx(out_opx), .out_src_a(out_src_a),
        .out_src_b(out_src_b), .out_dst(out_dst), .out_third_is_imm(out_third_is_imm),
        .out_third(out_third), .out_rnd_mode(out_rnd_mode), .out_rnd_valid(out_rnd_valid)
    );

    typedef struct packed {
        logic        has_pfx;
        logic [3:0]  w;
        logic [11:0] z;
        logic [7:0]  ii;
        logic [7:0]  op;
        logic [4:0]  rn, rm, ro;
        logic [5:0]  e_a, e_b, e_d;
        logic        e_timm;
        logic [7:0]  e_third, e_rnd;
        logic        e_rv;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        // R5 plain register class: third = destination
        '{1'b0, 4'h0, 12'h000, 8'h00, 8'h20, 5'd3, 5'd1, 5'd2, 6'd1, 6'd2, 6'd3, 1'b0, 8'd3, 8'h00, 1'b0, 8'd5},
        // R4 widening of all three, R5 prefixed register from byte, R10 byte not a mode
        '{1'b1, 4'h7, 12'h000, 8'h2A, 8'h20, 5'd3, 5'd1, 5'd2, 6'd33, 6'd34, 6'd35, 1'b0, 8'h2A, 8'h00, 1'b0, 8'd4},
        // R6 plain immediate class: third = 0
        '{1'b0, 4'h0, 12'h000, 8'h00, 8'h30, 5'd4, 5'd5, 5'd6, 6'd5, 6'd6, 6'd4, 1'b1, 8'h00, 8'h00, 1'b0, 8'd6},
        // R6 prefixed immediate = byte
        '{1'b1, 4'h0, 12'h000, 8'hC5, 8'h30, 5'd4, 5'd5, 5'd6, 6'd5, 6'd6, 6'd4, 1'b1, 8'hC5, 8'h00, 1'b0, 8'd6},
        // R8 prefixed FP add, destination widened
        '{1'b1, 4'h1, 12'h000, 8'h03, 8'h10, 5'd7, 5'd8, 5'd9, 6'd8, 6'd9, 6'd39, 1'b0, 8'd39, 8'h03, 1'b1, 8'd8},
        // R9 plain FP multiply: nearest-even, not valid
        '{1'b0, 4'h0, 12'h000, 8'h00, 8'h12, 5'd7, 5'd8, 5'd9, 6'd8, 6'd9, 6'd7, 1'b0, 8'd7, 8'h00, 1'b0, 8'd9},
        // R8 prefixed FP subtract, source A widened
        '{1'b1, 4'h2, 12'h000, 8'h01, 8'h11, 5'd10, 5'd11, 5'd12, 6'd43, 6'd12, 6'd10, 1'b0, 8'd10, 8'h01, 1'b1, 8'd8},
        // R7 default class ignores the byte (also R10)
        '{1'b1, 4'h0, 12'h000, 8'h55, 8'h01, 5'd2, 5'd3, 5'd4, 6'd3, 6'd4, 6'd2, 1'b0, 8'd2, 8'h00, 1'b0, 8'd7},
        // R11 nonzero opcode extension forces default class
        '{1'b1, 4'h0, 12'h001, 8'h77, 8'h30, 5'd1, 5'd2, 5'd3, 6'd2, 6'd3, 6'd1, 1'b0, 8'd1, 8'h00, 1'b0, 8'd11},
        // R8 prefixed FP multiply, high mode byte
        '{1'b1, 4'h0, 12'h000, 8'hE0, 8'h12, 5'd1, 5'd2, 5'd3, 6'd2, 6'd3, 6'd1, 1'b0, 8'd1, 8'hE0, 1'b1, 8'd8}
    };

    task automatic drive(input logic v, input logic [31:0] w);
        @(negedge clk);
        in_valid = v;
        in_word  = w;
    endtask

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [63:0] outs();
        return {5'd0, out_valid, out_illegal, out_prefixed, out_opcode, out_opx,
                out_src_a, out_src_b, out_dst, out_third_is_imm, out_third,
                out_rnd_mode, out_rnd_valid};
    endfunction

    function automatic logic [31:0] mk_insn(input logic [7:0] op, input logic [4:0] rn,
                                            input logic [4:0] rm, input logic [4:0] ro);
        return {op, rn, rm, ro, 9'h000};
    endfunction

    initial begin
        logic [63:0] exp;
        // R1 reset state
        repeat (3) @(negedge clk);
        chk(out_valid == 1'b0, "R1", "valid in reset", {63'd0, out_valid}, 64'd0);
        rst_n = 1'b1;
        drive(1'b0, 32'h0);
        chk(out_valid == 1'b0, "R1", "valid after reset", {63'd0, out_valid}, 64'd0);

        for (int i = 0; i < NV; i++) begin
            vec_t v;
            v = VECS[i];
            if (v.has_pfx) begin
                drive(1'b1, {8'hFF, v.w, v.z, v.ii});
                drive(1'b1, mk_insn(v.op, v.rn, v.rm, v.ro));
                chk(out_valid == 1'b0, "R3", "valid after prefix", {63'd0, out_valid}, 64'd0);
            end else begin
                drive(1'b1, mk_insn(v.op, v.rn, v.rm, v.ro));
            end
            drive(1'b0, 32'h0);
            exp = {5'd0, 1'b1, 1'b0, v.has_pfx, v.op, v.z, v.e_a, v.e_b, v.e_d,
                   v.e_timm, v.e_third, v.e_rnd, v.e_rv};
            chk(outs() == exp, $sformatf("R%0d", v.req), $sformatf("vector %0d", i), outs(), exp);
        end

        // R2 one-cycle pulse and in_valid low ignored
        drive(1'b0, mk_insn(8'h20, 5'd9, 5'd9, 5'd9));
        chk(out_valid == 1'b0, "R2", "pulse width", {63'd0, out_valid}, 64'd0);
        drive(1'b0, 32'h0);
        chk(out_valid == 1'b0, "R2", "invalid word ignored", {63'd0, out_valid}, 64'd0);

        // R3 prefix with gap cycles
        drive(1'b1, {8'hFF, 4'h4, 12'h000, 8'h06});
        for (int g = 0; g < 3; g++) begin
            drive(1'b0, 32'h0);
            chk(out_valid == 1'b0, "R3", "gap cycle", {63'd0, out_valid}, 64'd0);
        end
        drive(1'b1, mk_insn(8'h11, 5'd1, 5'd2, 5'd3));
        drive(1'b0, 32'h0);
        exp = {5'd0, 1'b1, 1'b0, 1'b1, 8'h11, 12'h000, 6'd2, 6'd35, 6'd1, 1'b0, 8'd1, 8'h06, 1'b1};
        chk(outs() == exp, "R3", "decode after gap (R4 source B)", outs(), exp);

        // R12 prefix after prefix
        drive(1'b1, {8'hFF, 4'h7, 12'h000, 8'h11});
        drive(1'b1, {8'hFF, 4'h0, 12'h000, 8'h22});
        drive(1'b0, 32'h0);
        exp = {5'd0, 1'b1, 1'b1, 57'd0};
        chk(outs() == exp, "R12", "double prefix", outs(), exp);
        drive(1'b1, mk_insn(8'h20, 5'd3, 5'd1, 5'd2));
        drive(1'b0, 32'h0);
        exp = {5'd0, 1'b1, 1'b0, 1'b0, 8'h20, 12'h000, 6'd1, 6'd2, 6'd3, 1'b0, 8'd3, 8'h00, 1'b0};
        chk(outs() == exp, "R12", "idle after illegal", outs(), exp);

        // R13 reserved prefix bit and reserved instruction bits
        drive(1'b1, {8'hFF, 4'h8, 12'h000, 8'h00});
        drive(1'b1, mk_insn(8'h20, 5'd3, 5'd1, 5'd2));
        drive(1'b0, 32'h0);
        exp = {5'd0, 1'b1, 1'b1, 57'd0};
        chk(outs() == exp, "R13", "reserved prefix bit", outs(), exp);
        drive(1'b1, mk_insn(8'h20, 5'd3, 5'd1, 5'd2) | 32'h1);
        drive(1'b0, 32'h0);
        chk(outs() == exp, "R13", "reserved insn bits", outs(), exp);

        // R1 reset while waiting discards the prefix
        drive(1'b1, {8'hFF, 4'h7, 12'h000, 8'h09});
        drive(1'b0, 32'h0);
        rst_n = 1'b0;
        drive(1'b0, 32'h0);
        rst_n = 1'b1;
        drive(1'b1, mk_insn(8'h10, 5'd4, 5'd5, 5'd6));
        drive(1'b0, 32'h0);
        exp = {5'd0, 1'b1, 1'b0, 1'b0, 8'h10, 12'h000, 6'd5, 6'd6, 6'd4, 1'b0, 8'd4, 8'h00, 1'b0};
        chk(outs() == exp, "R1", "reset drops prefix", outs(), exp);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog R3 actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end
endmodule